// File: doc/BRIEF.md
# Two-Channel Transmit Frame Buffer

This block sits between a processor register bus and a byte-wide Ethernet transmit path. It holds two frame buffers. Software picks one through a channel-select register. It loads the frame through a single data-port address, one 32-bit word per write, then programs the frame's byte count and sets a start bit. Until the start bit is set, nothing leaves the block. After that, the stored bytes stream out in order on a valid/ready byte interface.

Words are packed little-endian: byte 0 of each word is sent first. Bytes of the last word beyond the programmed length are dropped. Each channel keeps its own length and its own busy state, and only one channel drives the output at a time. Misuse raises a sticky error flag: data written into a channel that is still sending, and lengths above the buffer capacity.

Top module: `txbuf2ch`

## Requirements
- R1: After reset, tx_valid, chan_busy and err_flag are 0. Registers read back 0: select at address 0, length at address 2, control at address 3, status at address 4.
- R2: Bit 0 of a write to address 0 selects the channel targeted by later data, length and control accesses, and it reads back at address 0. A value of 0 selects channel 0.
- R3: Each write to address 1 stores one 32-bit word at the selected channel's next load position. Bits [7:0] are sent first, then [15:8], [23:16] and [31:24]. Exactly L bytes are sent for length L, and the rest of the last word is discarded.
- R4: Each channel has its own length register. A write to address 2 sets the selected channel's length, and address 2 reads back the selected channel's length.
- R5: Loading data or length never makes tx_valid rise. tx_valid is high only while some channel is busy.
- R6: Writing address 3 with bit 0 set, on an idle channel with non-zero length, makes it busy on the next cycle. tx_valid rises one cycle after that. Bit 0 of address 3 and chan_busy read 1 until the last byte is accepted, then clear. A start also rewinds that channel's load position to word 0.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R8: A data-port write to a busy channel changes no stored data and sets err_flag (status bit 0). The flag stays set until reset. So does a data write to a full buffer.
- R9: A length write above CAP_BYTES (2048) stores CAP_BYTES and sets err_flag. A length equal to CAP_BYTES is stored unchanged without error.
- R10: A channel started while the other is sending waits, then sends its whole frame after the first one completes.
- R11: A start with length 0 sends nothing and leaves the channel idle.
- R12: A write to address 3 with bit 0 clear does not start the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| chan_busy | output | 2 | Per-channel start-pending-or-sending flag |
| err_flag | output | 1 | Sticky misuse flag |

## Verification
Register effects show up at the first falling edge after the writing rising edge: stored length, busy, select and the error flag all read back there. The first byte appears with tx_valid at the second falling edge after the start write, because the start registers busy and the next edge arms the output. The bench drives on falling edges and samples on falling edges, so every read falls between the two edges that bound the expected change. A byte is recorded at the falling edge where tx_valid and tx_ready are both high, since the following rising edge consumes it. The done check comes after that edge, when chan_busy and tx_valid must already be low.

// File: rtl/txbuf2ch.sv
module txbuf2ch #(
  parameter int CAP_BYTES = 2048,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    chan_busy,
  output logic          err_flag
);
  localparam int WORDS = CAP_BYTES / 4;
  localparam int IW = $clog2(WORDS);
  localparam int PW = IW + 1;
  localparam int LW = $clog2(CAP_BYTES + 1);
  localparam int BW = $clog2(CAP_BYTES);
  localparam logic [AW-1:0] A_SEL  = AW'(0);
  localparam logic [AW-1:0] A_DATA = AW'(1);
  localparam logic [AW-1:0] A_LEN  = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic chsel, act, cur, err;
  logic [1:0] busy;
  logic [LW-1:0] bidx;
  logic [1:0][LW-1:0] flen;
  logic [1:0][PW-1:0] wptr;
  logic [1:0][31:0] rd_word;

  wire wr_sel  = bus_wr && bus_addr == A_SEL;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire wr_len  = bus_wr && bus_addr == A_LEN;
  wire wr_go   = bus_wr && bus_addr == A_CTRL && bus_wdata[0] && !busy[chsel];
  wire full    = wptr[chsel] == PW'(WORDS);
  wire load_ok = wr_data && !busy[chsel] && !full;
  wire too_big = bus_wdata > 32'(CAP_BYTES);
  wire last    = act && tx_ready && bidx == flen[cur] - LW'(1);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [31:0] store [WORDS];
    always_ff @(posedge clk)
      if (load_ok && chsel == 1'(c)) store[wptr[c][IW-1:0]] <= bus_wdata;
    assign rd_word[c] = store[bidx[BW-1:2]];

    always_ff @(posedge clk)
      if (!rst_n) begin
        wptr[c] <= '0;
        flen[c] <= '0;
        busy[c] <= 1'b0;
      end else begin
        if (wr_go && chsel == 1'(c)) begin
          wptr[c] <= '0;
          busy[c] <= flen[c] != '0;
        end else if (load_ok && chsel == 1'(c))
          wptr[c] <= wptr[c] + PW'(1);
        if (wr_len && chsel == 1'(c) && !busy[c])
          flen[c] <= too_big ? LW'(CAP_BYTES) : bus_wdata[LW-1:0];
        if (last && cur == 1'(c)) busy[c] <= 1'b0;
      end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      chsel <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (wr_sel) chsel <= bus_wdata[0];
      if ((wr_data && (busy[chsel] || full)) || (wr_len && !busy[chsel] && too_big))
        err <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      act  <= 1'b0;
      cur  <= 1'b0;
      bidx <= '0;
    end else if (!act) begin
      bidx <= '0;
      if (busy[0]) begin
        act <= 1'b1;
        cur <= 1'b0;
      end else if (busy[1]) begin
        act <= 1'b1;
        cur <= 1'b1;
      end
    end else if (tx_ready) begin
      if (last) act <= 1'b0;
      else bidx <= bidx + LW'(1);
    end

  assign tx_valid  = act;
  assign tx_data   = rd_word[cur][8*bidx[1:0] +: 8];
  assign chan_busy = busy;
  assign err_flag  = err;

  always_comb
    case (bus_addr)
      A_SEL:   bus_rdata = {31'd0, chsel};
      A_LEN:   bus_rdata = 32'(flen[chsel]);
      A_CTRL:  bus_rdata = {31'd0, busy[chsel]};
      A_STAT:  bus_rdata = {31'd0, err};
      default: bus_rdata = 32'd0;
    endcase
endmodule

// File: rtl/txbuf2ch_chk.sv
module txbuf2ch_chk #(
  parameter int CAP_BYTES = 2048,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [1:0]    chan_busy,
  input logic          err_flag,
  input logic          chsel
);
  p_valid_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> chan_busy != 2'b00);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_busy_load_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(1) && chan_busy[chsel] |=> err_flag);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_len_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(2) && !chan_busy[chsel] && bus_wdata > 32'(CAP_BYTES) |=> err_flag);
endmodule

bind txbuf2ch txbuf2ch_chk #(.CAP_BYTES(CAP_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .chan_busy(chan_busy), .err_flag(err_flag),
  .chsel(chsel)
);

// File: tb/sim_txbuf2ch.sv
`timescale 1ns/1ps
module sim_txbuf2ch;
  logic clk = 0, rst_n = 0, bus_wr = 0, tx_ready = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] tx_data;
  logic tx_valid, err_flag;
  logic [1:0] chan_busy;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] got [16];
  int ngot;

  always #2 clk = ~clk;

  txbuf2ch u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .chan_busy(chan_busy),
    .err_flag(err_flag));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset;
    rst_n = 0; tx_ready = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic collect(input int n);
    int guard = 0;
    ngot = 0;
    tx_ready = 1;
    while (ngot < n && guard < 200) begin
      if (tx_valid) begin
        got[ngot] = tx_data;
        ngot++;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_reset;
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 busy", 32'(chan_busy), 0);
    chk("R1 err", 32'(err_flag), 0);
    rd(0, v); chk("R1 sel", v, 0);
    rd(2, v); chk("R1 len", v, 0);
    rd(3, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    do_reset;
    wr(0, 0);
    wr(1, 32'h44332211);
    wr(1, 32'h88776655);
    wr(2, 7);
    tx_ready = 1;
    repeat (4) @(negedge clk);
    chk("R5 no send before start", 32'(tx_valid), 0);
    tx_ready = 0;
    wr(3, 1);
    chk("R6 valid not yet", 32'(tx_valid), 0);
    rd(3, v); chk("R6 ctrl busy", v, 1);
    @(negedge clk);
    chk("R6 valid due", 32'(tx_valid), 1);
    collect(7);
    chk("R3 count", 32'(ngot), 7);
    for (int i = 0; i < 7; i++) chk("R3 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    rd(3, v); chk("R6 ctrl clears", v, 0);
    chk("R3 no eighth byte", 32'(tx_valid), 0);
    chk("R6 busy port clears", 32'(chan_busy), 0);
    wr(1, 32'hDDCCBBAA);
    wr(2, 2);
    wr(3, 1);
    @(negedge clk);
    collect(2);
    chk("R6 rewind b0", 32'(got[0]), 32'hAA);
    chk("R6 rewind b1", 32'(got[1]), 32'hBB);
  endtask

  task automatic t_stall;
    logic [7:0] first;
    do_reset;
    wr(0, 1);
    wr(1, 32'h0302015A);
    wr(2, 4);
    wr(3, 1);
    @(negedge clk);
    first = tx_data;
    chk("R7 first byte", 32'(first), 32'h5A);
    repeat (3) begin
      @(negedge clk);
      chk("R7 valid held", 32'(tx_valid), 1);
      chk("R7 data held", 32'(tx_data), 32'(first));
    end
    collect(4);
    chk("R7 after stall", 32'(got[3]), 32'h03);
  endtask

  task automatic t_sel_len;
    logic [31:0] v;
    do_reset;
    wr(0, 0); wr(2, 5);
    wr(0, 1); wr(2, 9);
    rd(0, v); chk("R2 sel readback", v, 1);
    rd(2, v); chk("R4 ch1 len", v, 9);
    wr(0, 0);
    rd(0, v); chk("R2 sel zero", v, 0);
    rd(2, v); chk("R4 ch0 len", v, 5);
  endtask

  task automatic t_busy_write;
    logic [31:0] v;
    do_reset;
    wr(1, 32'h13121110);
    wr(1, 32'h17161514);
    wr(2, 8);
    wr(3, 1);
    @(negedge clk);
    wr(2, 3);
    rd(2, v); chk("R8 len kept while busy", v, 8);
    wr(1, 32'hFFFFFFFF);
    rd(4, v); chk("R8 err set", v, 1);
    collect(8);
    for (int i = 0; i < 8; i++) chk("R8 data untouched", 32'(got[i]), 32'(8'h10 + i));
    repeat (2) @(negedge clk);
    chk("R8 err sticky", 32'(err_flag), 1);
  endtask

  task automatic t_clamp;
    logic [31:0] v;
    do_reset;
    wr(2, 2048);
    rd(2, v); chk("R9 exact cap", v, 2048);
    chk("R9 no err at cap", 32'(err_flag), 0);
    wr(2, 5000);
    rd(2, v); chk("R9 clamped", v, 2048);
    chk("R9 err", 32'(err_flag), 1);
  endtask

  task automatic t_two;
    do_reset;
    wr(0, 0); wr(1, 32'hA3A2A1A0); wr(2, 4);
    wr(0, 1); wr(1, 32'hB3B2B1B0); wr(2, 4);
    wr(0, 0); wr(3, 1);
    wr(0, 1); wr(3, 1);
    chk("R10 both busy", 32'(chan_busy), 3);
    collect(8);
    chk("R10 count", 32'(ngot), 8);
    for (int i = 0; i < 4; i++) begin
      chk("R10 ch0 first", 32'(got[i]), 32'(8'hA0 + i));
      chk("R10 ch1 after", 32'(got[i+4]), 32'(8'hB0 + i));
    end
  endtask

  task automatic t_zero_and_nostart;
    do_reset;
    wr(1, 32'h01020304);
    wr(3, 1);
    tx_ready = 1;
    repeat (4) begin
      @(negedge clk);
      chk("R11 zero len no send", 32'(tx_valid), 0);
    end
    chk("R11 idle", 32'(chan_busy), 0);
    wr(2, 4);
    wr(3, 2);
    repeat (4) @(negedge clk);
    chk("R12 no start", 32'(tx_valid), 0);
    chk("R12 idle", 32'(chan_busy), 0);
    tx_ready = 0;
  endtask

  initial begin
    t_reset;
    t_basic;
    t_stall;
    t_sel_len;
    t_busy_write;
    t_clamp;
    t_two;
    t_zero_and_nostart;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule